// File: doc/BRIEF.md
# Narrow-to-Wide Register Access Bridge

This block lets a host that only has a 32-bit register port read and write 64-bit registers in a downstream engine. The host sees a small window of 32-bit registers. Two of them hold the upper and lower halves of a 64-bit value. One command word starts a single downstream transfer. The others are a reset register and a status register.

To write, the host loads both halves and then writes the command word with its top bit set. To read, it writes the command word with the top bit clear, polls status until the busy bit drops, and then reads the two halves. The downstream side is a synchronous 64-bit register bus. A request is held until the engine acknowledges it, and the acknowledge may carry an error response. A sticky error flag records every failure: an error response, a timeout, or a command that arrives while a transfer is still running.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset, status reads 0, both data halves read 0 and `dn_req` is low.
- R2: A command write with bit 31 = 1 starts a downstream write. The address is command bits 30:0 and the write data is {upper half at offset 0x00, lower half at offset 0x04}. Address, direction and data stay stable until the transfer ends.
- R3: A command write with bit 31 = 0 starts a downstream read. On an error-free acknowledge, bits 63:32 of the returned value appear at offset 0x00 and bits 31:0 at offset 0x04.
- R4: Status bit 0 (busy) reads 1 from the cycle after the command write until the cycle after the acknowledge. It reads 0 otherwise.
- R5: An acknowledge that carries an error sets status bit 31. That flag stays set through later successful transfers.
- R6: A command write while busy does not change the transfer in flight, and it sets status bit 31.
- R7: If no acknowledge arrives, the request is withdrawn after exactly TIMEOUT_CYCLES cycles (default 256) and status bit 31 is set.
- R8: A write of any value to offset 0x18 clears status bit 31 and ends a transfer in flight. The next cycle shows `dn_req` low and status 0.
- R9: Offsets 0x08, 0x18, 0x20 and every unmapped offset read as 0.
- R10: A read that ends in an error response leaves both data halves unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | OFS_W | Host byte offset into the window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr` (combinational) |
| dn_req | output | 1 | Downstream request, held until acknowledge |
| dn_we | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | 31 | Downstream register address |
| dn_wdata | output | 64 | Downstream write data |
| dn_ack | input | 1 | Downstream acknowledge (one-cycle pulse) |
| dn_err | input | 1 | Error response, valid with `dn_ack` |
| dn_rdata | input | 64 | Downstream read data, valid with `dn_ack` |

## Verification
A table of writes and read-backs runs through a register-file model of the engine. The table uses distinct upper and lower halves and overwrites one address, so swapped halves, lost data and stale data each show up as a mismatch. Directed cases then drive the error-response address, an address that never acknowledges, a second command while busy, and a reset write during a stalled transfer. Each case separates the sticky-flag, abort and ignore paths from a normal completion. The timeout case counts the request cycles, so an off-by-one limit is exposed.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    localparam int HOST_W    = 32;
    localparam int WIDE_W    = 64;
    localparam int DN_ADDR_W = HOST_W - 1;

    localparam logic [7:0] OFS_UPPER = 8'h00;
    localparam logic [7:0] OFS_LOWER = 8'h04;
    localparam logic [7:0] OFS_CMD   = 8'h08;
    localparam logic [7:0] OFS_CLEAR = 8'h18;
    localparam logic [7:0] OFS_STAT  = 8'h1C;
    localparam logic [7:0] OFS_IRQ   = 8'h20;

    typedef enum logic [2:0] {
        SEL_UPPER, SEL_LOWER, SEL_CMD, SEL_CLEAR, SEL_STAT, SEL_IRQ, SEL_NONE
    } win_sel_e;

    typedef struct packed {
        logic                 write;
        logic [DN_ADDR_W-1:0] addr;
    } cmd_t;

    typedef enum logic {XF_IDLE, XF_WAIT} xfer_state_e;

    function automatic win_sel_e decode_offset(input logic [7:0] ofs);
        case (ofs)
            OFS_UPPER: return SEL_UPPER;
            OFS_LOWER: return SEL_LOWER;
            OFS_CMD:   return SEL_CMD;
            OFS_CLEAR: return SEL_CLEAR;
            OFS_STAT:  return SEL_STAT;
            OFS_IRQ:   return SEL_IRQ;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [HOST_W-1:0] pack_status(input logic err, input logic busy);
        return {err, {(HOST_W-2){1'b0}}, busy};
    endfunction
endpackage

// File: rtl/bridge_window_regs.sv
module bridge_window_regs
    import bridge_pkg::*;
#(
    parameter int OFS_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [OFS_W-1:0]  host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    input  logic              load_en,
    input  logic [WIDE_W-1:0] load_data,
    input  logic              busy,
    input  logic              err_flag,
    output logic [WIDE_W-1:0] staged_data,
    output logic              cmd_pulse,
    output cmd_t              cmd_word,
    output logic              clear_pulse
);
    logic [HOST_W-1:0] upper_q, lower_q;
    win_sel_e          sel;

    assign sel         = decode_offset(8'(host_addr));
    assign cmd_pulse   = host_wr_en && (sel == SEL_CMD);
    assign clear_pulse = host_wr_en && (sel == SEL_CLEAR);
    assign cmd_word    = cmd_t'(host_wdata);
    assign staged_data = {upper_q, lower_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            lower_q <= '0;
        end else if (load_en) begin
            upper_q <= load_data[WIDE_W-1:HOST_W];
            lower_q <= load_data[HOST_W-1:0];
        end else if (host_wr_en) begin
            if (sel == SEL_UPPER) upper_q <= host_wdata;
            if (sel == SEL_LOWER) lower_q <= host_wdata;
        end
    end

    always_comb begin
        case (sel)
            SEL_UPPER: host_rdata = upper_q;
            SEL_LOWER: host_rdata = lower_q;
            SEL_STAT:  host_rdata = pack_status(err_flag, busy);
            default:   host_rdata = '0;
        endcase
    end

    // R3
    read_return_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (staged_data == $past(load_data)));

    // R10
    halves_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !host_wr_en) |=> $stable(staged_data));
endmodule

// File: rtl/bridge_xfer_ctrl.sv
module bridge_xfer_ctrl
    import bridge_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_pulse,
    input  cmd_t                 cmd_word,
    input  logic                 clear_pulse,
    input  logic [WIDE_W-1:0]    staged_data,
    output logic                 busy,
    output logic                 err_flag,
    output logic                 load_en,
    output logic [WIDE_W-1:0]    load_data,
    output logic                 dn_req,
    output logic                 dn_we,
    output logic [DN_ADDR_W-1:0] dn_addr,
    output logic [WIDE_W-1:0]    dn_wdata,
    input  logic                 dn_ack,
    input  logic                 dn_err,
    input  logic [WIDE_W-1:0]    dn_rdata
);
    localparam int CNT_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    xfer_state_e      state;
    logic [CNT_W-1:0] wait_cnt;
    logic             expired;

    assign busy      = (state == XF_WAIT);
    assign dn_req    = busy;
    assign expired   = (wait_cnt == CNT_LAST);
    assign load_en   = busy && dn_ack && !dn_err && !dn_we && !clear_pulse;
    assign load_data = dn_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= XF_IDLE;
            err_flag <= 1'b0;
            wait_cnt <= '0;
            dn_we    <= 1'b0;
            dn_addr  <= '0;
            dn_wdata <= '0;
        end else if (clear_pulse) begin
            state    <= XF_IDLE;
            err_flag <= 1'b0;
            wait_cnt <= '0;
        end else begin
            case (state)
                XF_IDLE: begin
                    if (cmd_pulse) begin
                        state    <= XF_WAIT;
                        wait_cnt <= '0;
                        dn_we    <= cmd_word.write;
                        dn_addr  <= cmd_word.addr;
                        dn_wdata <= staged_data;
                    end
                end
                XF_WAIT: begin
                    if (cmd_pulse) err_flag <= 1'b1;
                    if (dn_ack) begin
                        state <= XF_IDLE;
                        if (dn_err) err_flag <= 1'b1;
                    end else if (expired) begin
                        state    <= XF_IDLE;
                        err_flag <= 1'b1;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: state <= XF_IDLE;
            endcase
        end
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_req && !dn_ack && !expired && !clear_pulse) |=>
            (dn_req && $stable(dn_addr) && $stable(dn_we) && $stable(dn_wdata)));

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !clear_pulse) |=> err_flag);

    // R6
    cmd_busy_err_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_req && cmd_pulse && !clear_pulse) |=> err_flag);

    // R7
    timeout_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_req && !dn_ack && expired && !clear_pulse) |=> (!dn_req && err_flag));

    // R8
    clear_abort_chk: assert property (@(posedge clk) disable iff (rst)
        clear_pulse |=> (!dn_req && !err_flag));
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
    import bridge_pkg::*;
#(
    parameter int OFS_W          = 6,
    parameter int TIMEOUT_CYCLES = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_wr_en,
    input  logic [OFS_W-1:0]     host_addr,
    input  logic [HOST_W-1:0]    host_wdata,
    output logic [HOST_W-1:0]    host_rdata,
    output logic                 dn_req,
    output logic                 dn_we,
    output logic [DN_ADDR_W-1:0] dn_addr,
    output logic [WIDE_W-1:0]    dn_wdata,
    input  logic                 dn_ack,
    input  logic                 dn_err,
    input  logic [WIDE_W-1:0]    dn_rdata
);
    logic              busy, err_flag, load_en, cmd_pulse, clear_pulse;
    logic [WIDE_W-1:0] load_data, staged_data;
    cmd_t              cmd_word;

    bridge_window_regs #(.OFS_W(OFS_W)) u_win (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .load_en(load_en), .load_data(load_data),
        .busy(busy), .err_flag(err_flag),
        .staged_data(staged_data), .cmd_pulse(cmd_pulse),
        .cmd_word(cmd_word), .clear_pulse(clear_pulse)
    );

    bridge_xfer_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
        .clk(clk), .rst(rst),
        .cmd_pulse(cmd_pulse), .cmd_word(cmd_word),
        .clear_pulse(clear_pulse), .staged_data(staged_data),
        .busy(busy), .err_flag(err_flag),
        .load_en(load_en), .load_data(load_data),
        .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr),
        .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_err(dn_err),
        .dn_rdata(dn_rdata)
    );
endmodule

// File: tb/test_wide_reg_bridge.sv
module test_wide_reg_bridge;
    localparam int TMO = 256;
    localparam int LAT = 3;
    localparam logic [30:0] SILENT = 31'h7FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        dn_req, dn_we, dn_ack, dn_err;
    logic [30:0] dn_addr;
    logic [63:0] dn_wdata, dn_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wide_reg_bridge #(.OFS_W(6), .TIMEOUT_CYCLES(TMO)) i_wide_reg_bridge (
        .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_ack(dn_ack), .dn_err(dn_err), .dn_rdata(dn_rdata)
    );

    // Engine model: 16-entry register file, error for addr >= 16, no reply at SILENT.
    logic [63:0] regs [16];
    int          lat_cnt;
    always @(posedge clk) begin
        if (rst) begin
            dn_ack <= 1'b0; dn_err <= 1'b0; dn_rdata <= '0; lat_cnt <= 0;
            for (int i = 0; i < 16; i++) regs[i] <= '0;
        end else if (dn_req && !dn_ack && dn_addr != SILENT) begin
            if (lat_cnt == LAT - 1) begin
                lat_cnt  <= 0;
                dn_ack   <= 1'b1;
                dn_err   <= |dn_addr[30:4];
                dn_rdata <= regs[dn_addr[3:0]];
                if (!(|dn_addr[30:4]) && dn_we) regs[dn_addr[3:0]] <= dn_wdata;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            dn_ack <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic hread(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int n = 0; n < 400; n++) begin
            hread(6'h1C, s);
            if (!s[0]) break;
        end
    endtask

    task automatic read64(output logic [63:0] v);
        logic [31:0] h, l;
        hread(6'h00, h);
        hread(6'h04, l);
        v = {h, l};
    endtask

    typedef struct packed {
        logic        wr;
        logic [30:0] addr;
        logic [63:0] val;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 31'd3, 64'hA5A5_0001_5A5A_0002},
        '{1'b1, 31'd7, 64'h0123_4567_89AB_CDEF},
        '{1'b0, 31'd3, 64'hA5A5_0001_5A5A_0002},
        '{1'b0, 31'd7, 64'h0123_4567_89AB_CDEF},
        '{1'b1, 31'd3, 64'hFFFF_0000_0000_FFFF},
        '{1'b0, 31'd3, 64'hFFFF_0000_0000_FFFF}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] s;
        logic [63:0] v, keep;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        hread(6'h1C, s); check(s == 0, "R1 status", 64'(s), 0);
        read64(v);       check(v == 0, "R1 halves", v, 0);
        check(dn_req == 0, "R1 dn_req", 64'(dn_req), 0);

        // table walk: R2 writes, R3 reads, R4 busy
        foreach (VECS[k]) begin
            if (VECS[k].wr) begin
                hwrite(6'h00, VECS[k].val[63:32]);
                hwrite(6'h04, VECS[k].val[31:0]);
                hwrite(6'h08, {1'b1, VECS[k].addr});
                #1;
                check(dn_req && dn_we && dn_addr == VECS[k].addr && dn_wdata == VECS[k].val,
                      "R2 write request", dn_wdata, VECS[k].val);
            end else begin
                hwrite(6'h08, {1'b0, VECS[k].addr});
                #1;
                check(dn_req && !dn_we && dn_addr == VECS[k].addr, "R3 read request",
                      64'(dn_addr), 64'(VECS[k].addr));
            end
            hread(6'h1C, s); check(s == 32'h1, "R4 busy set", 64'(s), 1);
            wait_idle();
            hread(6'h1C, s); check(s == 0, "R4 busy clear", 64'(s), 0);
            if (!VECS[k].wr) begin
                read64(v); check(v == VECS[k].val, "R3 read data", v, VECS[k].val);
            end
        end

        // R6 command while busy
        hwrite(6'h08, {1'b0, 31'd7});
        hwrite(6'h08, {1'b1, 31'd2});
        #1 check(dn_req && !dn_we && dn_addr == 31'd7, "R6 flight unchanged", 64'(dn_addr), 7);
        wait_idle();
        hread(6'h1C, s); check(s == 32'h8000_0000, "R6 err set", 64'(s), 64'h8000_0000);
        read64(v); check(v == 64'h0123_4567_89AB_CDEF, "R6 first data", v, 64'h0123_4567_89AB_CDEF);

        // R8 clear, then R10 error read keeps halves, R5 sticky
        hwrite(6'h18, 32'h0);
        hread(6'h1C, s); check(s == 0, "R8 clear err", 64'(s), 0);
        read64(keep);
        hwrite(6'h08, {1'b0, 31'd20});
        wait_idle();
        read64(v); check(v == keep, "R10 halves kept", v, keep);
        hread(6'h1C, s); check(s == 32'h8000_0000, "R5 err on response", 64'(s), 64'h8000_0000);
        hwrite(6'h08, {1'b0, 31'd3});
        wait_idle();
        hread(6'h1C, s); check(s == 32'h8000_0000, "R5 err sticky", 64'(s), 64'h8000_0000);
        read64(v); check(v == 64'hFFFF_0000_0000_FFFF, "R5 later read ok", v, 64'hFFFF_0000_0000_FFFF);

        // R7 timeout length
        hwrite(6'h18, 32'h0);
        hwrite(6'h08, {1'b0, SILENT});
        n = 0;
        while (dn_req && n < 1000) begin n++; @(negedge clk); end
        check(n == TMO, "R7 request cycles", 64'(n), 64'(TMO));
        hread(6'h1C, s); check(s == 32'h8000_0000, "R7 err set", 64'(s), 64'h8000_0000);

        // R8 abort in flight
        hwrite(6'h18, 32'h0);
        hwrite(6'h08, {1'b1, SILENT});
        repeat (5) @(negedge clk);
        hwrite(6'h18, 32'hDEAD_BEEF);
        #1 check(dn_req == 0, "R8 abort req", 64'(dn_req), 0);
        hread(6'h1C, s); check(s == 0, "R8 abort status", 64'(s), 0);

        // R9 zero-read offsets
        hread(6'h08, s); check(s == 0, "R9 cmd reads 0", 64'(s), 0);
        hread(6'h18, s); check(s == 0, "R9 reset reads 0", 64'(s), 0);
        hread(6'h20, s); check(s == 0, "R9 irq reads 0", 64'(s), 0);
        hread(6'h10, s); check(s == 0, "R9 unmapped reads 0", 64'(s), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule